// File: doc/BRIEF.md
# Serial ROM Identifier CRC Checker

This block checks a 64-bit device identifier as it arrives at a bus host. The identifier comes in one bit per clock on `bit_in`, least significant bit first, and each bit is qualified by `bit_valid`. The first byte is a family code and the next 48 bits are a serial number. A bit-serial, reflected CRC-8 runs over these 56 bits. The generator polynomial is x^8 + x^5 + x^4 + 1, which is 0x8C in reflected form. The last byte received is the CRC that the sender attached.

When the 64th bit is accepted, the block raises a one-cycle `done` pulse. At that edge it latches two flags. `crc_ok` tells whether the computed CRC equals the attached byte. `family_ok` tells whether the family code equals a parameterised expected value. The block only reports. It never blocks or retries anything, and any action on a mismatch belongs to the surrounding host logic. A synchronous `start` prepares the block for the next identifier.

Top module: `romid_crc_checker`

## Requirements
- R1: Accepted bit k (counting from 0) belongs to the family code for k = 0..7 and to the serial number for k = 8..55. The bits are reassembled so that `family_code[0]` and `serial_num[0]` hold the first bit of their field.
- R2: `crc_value` is zero after `start`. For each of accepted bits 0..55 it updates as fb = crc[0] ^ bit, crc = crc >> 1, and then crc ^= 0x8C if fb = 1. Accepted bits 56..63 leave it unchanged.
- R3: At the edge that accepts bit 63, `crc_ok` is set to 1 if and only if `crc_value` equals the trailing byte (bits 56..63, LSB first). An all-zero identifier gives `crc_value` = 0x00 and `crc_ok` = 1.
- R4: Flipping any single bit among bits 0..55 of a correct identifier gives `crc_ok` = 0.
- R5: At the same edge, `family_ok` is set to 1 if and only if `family_code` equals parameter `FAMILY_EXP` (default 0x34).
- R6: Cycles with `bit_valid` = 0 change no output.
- R7: `done` is high for exactly the one cycle after the edge that accepts bit 63. The new `crc_ok` and `family_ok` values are visible in that same cycle.
- R8: Once 64 bits have been accepted, further valid bits are ignored until the next `start`. `done` stays low, and the flags, `crc_value` and the captured fields hold.
- R9: `start` synchronously clears the bit count, `crc_value`, `family_code`, `serial_num`, the trailing-byte capture and both flags. A bit presented together with `start` is dropped.
- R10: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new identifier, clears all state |
| bit_valid | input | 1 | Qualifies `bit_in` this cycle |
| bit_in | input | 1 | Serial identifier bit, LSB first |
| crc_value | output | 8 | CRC computed over the first 56 bits |
| family_code | output | 8 | Captured family-code byte |
| serial_num | output | 48 | Captured serial number |
| done | output | 1 | One-cycle pulse after the 64th accepted bit |
| crc_ok | output | 1 | Computed CRC equals the trailing byte |
| family_ok | output | 1 | Family code equals `FAMILY_EXP` |

## Verification
Several assertions assume that a new identifier cannot finish again right after `done`. They rely on `start` and 64 further valid bits being needed before any new result appears, so `done` can never be high on two cycles in a row. They also assume that a cycle with neither `start` nor `bit_valid` moves no state. The stimulus changes inputs only on falling clock edges and raises `start` only as an isolated pulse. It inserts idle gaps between bits, presents `start` together with a bit, and sends surplus bits after a frame, all within these assumptions.

// File: rtl/romid_pkg.sv
// Package: shared types for the identifier checker.
// Assumes the identifier is split into family, serial and trailer fields
// that arrive in that order.
package romid_pkg;
    typedef enum logic [1:0] {
        PH_FAMILY  = 2'd0,
        PH_SERIAL  = 2'd1,
        PH_TRAILER = 2'd2,
        PH_FULL    = 2'd3
    } phase_e;
endpackage

// File: rtl/romid_bit_counter.sv
// Counts accepted identifier bits and decodes which field the current bit
// belongs to. Assumes start is a one-cycle request. The count saturates at
// ID_BITS, so surplus bits are refused until the next start.
module romid_bit_counter
    import romid_pkg::*;
#(
    parameter int ID_BITS  = 64,
    parameter int FAM_BITS = 8,
    parameter int CRC_BITS = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   bit_valid,
    output logic   accept,
    output logic   last_bit,
    output phase_e phase
);
    localparam int CNT_W     = $clog2(ID_BITS + 1);
    localparam int SER_END   = ID_BITS - CRC_BITS;

    logic [CNT_W-1:0] cnt;

    // Bit count: cleared by start, advanced on each accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n || start) cnt <= '0;
        else if (accept)     cnt <= cnt + 1'b1;
    end

    // Field decode of the current count.
    always_comb begin
        if (cnt < CNT_W'(FAM_BITS))     phase = PH_FAMILY;
        else if (cnt < CNT_W'(SER_END)) phase = PH_SERIAL;
        else if (cnt < CNT_W'(ID_BITS)) phase = PH_TRAILER;
        else                            phase = PH_FULL;
    end

    // Acceptance: a valid bit, no start, and room left in the frame.
    always_comb begin
        accept   = bit_valid && !start && (phase != PH_FULL);
        last_bit = accept && (cnt == CNT_W'(ID_BITS - 1));
    end

    // R6
    idle_count_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !bit_valid) |=> $stable(cnt));
    // R8
    full_count_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && phase == PH_FULL) |=> (phase == PH_FULL));
endmodule

// File: rtl/romid_crc_lfsr.sv
// Reflected bit-serial CRC register. Assumes bits arrive LSB first.
// Each enabled bit shifts right, and POLY is folded in when the feedback bit is 1.
module romid_crc_lfsr #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   POLY = 8'h8C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc
);
    logic         fb;
    logic [W-1:0] nxt;

    // Next value of the register for one input bit.
    always_comb begin
        fb  = crc[0] ^ din;
        nxt = (crc >> 1) ^ (fb ? POLY : '0);
    end

    // CRC state: cleared by clr, advanced on en.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc <= '0;
        else if (en)       crc <= nxt;
    end

    // R9
    crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == '0));
    // R2
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(crc));
endmodule

// File: rtl/romid_shift_capture.sv
// LSB-first capture register. Each enabled bit enters at the top and moves
// toward bit 0, so after W bits q[0] holds the first bit received.
module romid_shift_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    // Capture shift: cleared by clr, shifts right on en.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else if (en)       q <= {din, q[W-1:1]};
    end

    // R1
    capture_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (q[W-1] == $past(din)));
endmodule

// File: rtl/romid_crc_checker.sv
// Top: checks a serially received identifier made of a family code, a serial
// number and a trailing CRC byte. Assumes LSB-first bits qualified by
// bit_valid and a one-cycle start before each identifier. It reports
// crc_ok and family_ok and takes no action on a mismatch.
module romid_crc_checker
    import romid_pkg::*;
#(
    parameter int                   ID_BITS       = 64,
    parameter int                   FAM_BITS      = 8,
    parameter int                   CRC_BITS      = 8,
    parameter logic [CRC_BITS-1:0]  CRC_POLY_REFL = 8'h8C,
    parameter logic [FAM_BITS-1:0]  FAMILY_EXP    = 8'h34,
    localparam int                  SER_BITS      = ID_BITS - FAM_BITS - CRC_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                bit_valid,
    input  logic                bit_in,
    output logic [CRC_BITS-1:0] crc_value,
    output logic [FAM_BITS-1:0] family_code,
    output logic [SER_BITS-1:0] serial_num,
    output logic                done,
    output logic                crc_ok,
    output logic                family_ok
);
    logic                accept;
    logic                last_bit;
    phase_e              phase;
    logic [CRC_BITS-1:0] trail_q;
    logic [CRC_BITS-1:0] trail_final;

    romid_bit_counter #(
        .ID_BITS (ID_BITS),
        .FAM_BITS(FAM_BITS),
        .CRC_BITS(CRC_BITS)
    ) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .bit_valid(bit_valid),
        .accept   (accept),
        .last_bit (last_bit),
        .phase    (phase)
    );

    romid_crc_lfsr #(
        .W   (CRC_BITS),
        .POLY(CRC_POLY_REFL)
    ) i_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start),
        .en   (accept && (phase != PH_TRAILER)),
        .din  (bit_in),
        .crc  (crc_value)
    );

    romid_shift_capture #(.W(FAM_BITS)) i_family (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start),
        .en   (accept && (phase == PH_FAMILY)),
        .din  (bit_in),
        .q    (family_code)
    );

    romid_shift_capture #(.W(SER_BITS)) i_serial (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start),
        .en   (accept && (phase == PH_SERIAL)),
        .din  (bit_in),
        .q    (serial_num)
    );

    romid_shift_capture #(.W(CRC_BITS)) i_trailer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start),
        .en   (accept && (phase == PH_TRAILER)),
        .din  (bit_in),
        .q    (trail_q)
    );

    // Trailing byte as it stands once the final bit is included.
    always_comb trail_final = {bit_in, trail_q[CRC_BITS-1:1]};

    // Result flags and done pulse, latched on the last accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            done      <= 1'b0;
            crc_ok    <= 1'b0;
            family_ok <= 1'b0;
        end else begin
            done <= last_bit;
            if (last_bit) begin
                crc_ok    <= (crc_value == trail_final);
                family_ok <= (family_code == FAMILY_EXP);
            end
        end
    end

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    flags_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !bit_valid) |=> ($stable(crc_ok) && $stable(family_ok)));
    // R9
    start_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && !crc_ok && !family_ok));
    // R8
    full_frame_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && phase == PH_FULL) |=> (!done && $stable(crc_value)));
endmodule

// File: tb/test_romid_crc_checker.sv
`timescale 1ns/1ps
module test_romid_crc_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic [7:0]  crc_value;
    logic [7:0]  family_code;
    logic [47:0] serial_num;
    logic        done;
    logic        crc_ok;
    logic        family_ok;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    romid_crc_checker i_romid_crc_checker (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_valid(bit_valid),
        .bit_in(bit_in), .crc_value(crc_value), .family_code(family_code),
        .serial_num(serial_num), .done(done), .crc_ok(crc_ok),
        .family_ok(family_ok)
    );

    task automatic chk(input bit cond, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [55:0] d);
        logic [7:0] c = 8'h00;
        for (int k = 0; k < 56; k++) begin
            logic fb = c[0] ^ d[k];
            c = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    function automatic logic [63:0] make_id(input logic [7:0] fam, input logic [47:0] ser);
        return {ref_crc({ser, fam}), ser, fam};
    endfunction

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // Sends 64 bits LSB first; returns at the negedge after the last edge.
    task automatic send_id(input logic [63:0] id, input bit gaps);
        for (int i = 0; i < 64; i++) begin
            if (gaps && (i % 3 == 0)) begin
                @(negedge clk); bit_valid = 1'b0; bit_in = ~id[i];
            end
            @(negedge clk); bit_valid = 1'b1; bit_in = id[i];
        end
        @(negedge clk); bit_valid = 1'b0;
    endtask

    task automatic check_frame(input logic [63:0] id, input bit exp_crc_ok,
                               input bit exp_fam_ok, input string tag);
        chk(done == 1'b1, {"R7 done ", tag}, done, 1);
        chk(crc_value == ref_crc(id[55:0]), {"R2 crc ", tag}, crc_value, ref_crc(id[55:0]));
        chk(crc_ok == exp_crc_ok, {"R3 crc_ok ", tag}, crc_ok, exp_crc_ok);
        chk(family_ok == exp_fam_ok, {"R5 family_ok ", tag}, family_ok, exp_fam_ok);
        chk(family_code == id[7:0], {"R1 family ", tag}, family_code, id[7:0]);
        chk(serial_num == id[55:8], {"R1 serial ", tag}, serial_num, id[55:8]);
        @(negedge clk);
        chk(done == 1'b0, {"R7 done width ", tag}, done, 0);
    endtask

    task automatic t_reset();
        chk({crc_value, family_code, done, crc_ok, family_ok} == '0 && serial_num == '0,
            "R10 reset outputs", {crc_value, family_code, done, crc_ok, family_ok}, 0);
    endtask

    task automatic t_all_zero();
        pulse_start();
        send_id(64'h0, 1'b0);
        chk(crc_value == 8'h00, "R3 zero crc", crc_value, 0);
        check_frame(64'h0, 1'b1, 1'b0, "all-zero");
    endtask

    task automatic t_good_id(input logic [47:0] ser, input bit gaps);
        logic [63:0] id = make_id(8'h34, ser);
        pulse_start();
        send_id(id, gaps);
        check_frame(id, 1'b1, 1'b1, gaps ? "R6 gapped" : "good");
    endtask

    task automatic t_wrong_family();
        logic [63:0] id = make_id(8'h28, 48'h0000_1234_ABCD);
        pulse_start();
        send_id(id, 1'b0);
        check_frame(id, 1'b1, 1'b0, "R5 other family");
    endtask

    task automatic t_flip(input int pos);
        logic [63:0] id = make_id(8'h34, 48'h5A5A_0F0F_C3C3);
        id[pos] = ~id[pos];
        pulse_start();
        send_id(id, 1'b0);
        chk(crc_ok == 1'b0, $sformatf("R4 flip bit %0d", pos), crc_ok, 0);
        @(negedge clk);
    endtask

    task automatic t_idle_gap_no_effect();
        logic [7:0]  c;
        logic [47:0] s;
        pulse_start();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); bit_valid = 1'b1; bit_in = i[0];
        end
        @(negedge clk); bit_valid = 1'b0; c = crc_value; s = serial_num;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); bit_in = ~bit_in;
        end
        chk(crc_value == c && serial_num == s, "R6 idle no effect", {crc_value, s[7:0]}, {c, s[7:0]});
    endtask

    task automatic t_surplus_bits();
        logic [63:0] id = make_id(8'h34, 48'h8000_0000_0001);
        logic        seen_done = 1'b0;
        pulse_start();
        send_id(id, 1'b0);
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); bit_valid = 1'b1; bit_in = 1'b1;
            if (done) seen_done = 1'b1;
        end
        @(negedge clk); bit_valid = 1'b0;
        if (done) seen_done = 1'b1;
        chk(!seen_done, "R8 no extra done", seen_done, 0);
        chk(crc_ok && family_ok, "R8 flags held", {crc_ok, family_ok}, 2'b11);
        chk(crc_value == id[63:56] && serial_num == id[55:8] && family_code == id[7:0],
            "R8 captures held", crc_value, id[63:56]);
    endtask

    task automatic t_restart();
        logic [63:0] id = make_id(8'h34, 48'hDEAD_BEEF_0042);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); bit_valid = 1'b1; bit_in = 1'b1;
        end
        // start together with a valid bit: the bit must be dropped
        @(negedge clk); start = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
        @(negedge clk); start = 1'b0; bit_valid = 1'b0;
        chk(crc_value == 8'h00 && family_code == 8'h00 && serial_num == '0 && !crc_ok,
            "R9 start clears", {crc_value, family_code}, 0);
        send_id(id, 1'b0);
        check_frame(id, 1'b1, 1'b1, "R9 restart");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_all_zero();
        t_good_id(48'h0123_4567_89AB, 1'b0);
        t_good_id(48'hFFFF_FFFF_FFFF, 1'b1);
        t_wrong_family();
        t_flip(0);
        t_flip(7);
        t_flip(30);
        t_flip(55);
        t_idle_gap_no_effect();
        t_surplus_bits();
        t_restart();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule